// File: doc/BRIEF.md
# Banked Context and Thread Identifier Register File

This block keeps the identifier registers that an operating system uses to tag the running process and thread. There are four 32-bit registers: a context identifier (address-space tag in the low byte, process tag above it), a thread register open to User mode for reading and writing, a thread register that User mode may only read, and a thread register reserved for privileged code. Each of the two security worlds has its own copy of all four, and every register starts at zero.

Software reaches the registers through a coprocessor-style access port. One cycle after an access, the block answers in one of three ways. It returns read data with a valid strobe, or it raises an undefined-instruction flag when the mode may not make that access, or it stays silent when the access does not address this block. A permitted write to the context identifier also produces a one-cycle branch-cache flush pulse. The address-space tag of the current world's context identifier is driven to the MMU at all times. The port's security bit tells the block which world the core is in, whether or not an access is under way.

Top module: `ctxid_regfile`

## Requirements
- R1: An access is addressed to the block only when acc_op1 is 0, acc_crn is 13 and acc_crm is 0. acc_op2 then picks the register: 1 context identifier, 2 User read/write thread, 3 User read-only thread, 4 privileged-only thread. A permitted read returns the register's value on rd_data with rd_valid high in the cycle after the access. At all other times rd_data is 0.
- R2: Each register has two independent copies, selected by acc_ns (0 secure, 1 non-secure). A write to one world's copy never changes the other world's copy. Every copy reads 0 after reset.
- R3: The context identifier (acc_op2=1) can be read and written only when acc_priv is 1. A User access (acc_priv=0) of either kind sets undef_exc in the next cycle.
- R4: The User read/write thread register (acc_op2=2) can be read and written with acc_priv at 0 or 1.
- R5: The User read-only thread register (acc_op2=3) can be read in User mode, and a User write sets undef_exc. Privileged code can both read and write it.
- R6: Any User read or write of the privileged-only thread register (acc_op2=4) sets undef_exc. Privileged code can read and write it.
- R7: A permitted write to the context identifier sets bt_flush for exactly the next cycle. No other access sets it.
- R8: mmu_asid always equals bits [7:0] of the context identifier of the world that acc_ns selects. It follows a write in the cycle after the write.
- R9: An access that raises undef_exc leaves every register unchanged, and it returns 0 on rd_data with rd_valid low.
- R10: An access that is not addressed to the block produces no rd_valid, no undef_exc and no bt_flush, and it changes no register. This covers any acc_op2 outside 1..4 and any other acc_op1, acc_crn or acc_crm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 write, 0 read |
| acc_op1 | input | 3 | Primary opcode selector, must be 0 |
| acc_crn | input | 4 | Primary register selector, must be 13 |
| acc_crm | input | 4 | Secondary register selector, must be 0 |
| acc_op2 | input | 3 | Register choice within the block |
| acc_wdata | input | 32 | Write data |
| acc_ns | input | 1 | Current security world, 1 non-secure |
| acc_priv | input | 1 | 1 privileged mode, 0 User mode |
| rd_data | output | 32 | Read response data, 0 when not valid |
| rd_valid | output | 1 | Read response strobe |
| undef_exc | output | 1 | Undefined-instruction response |
| bt_flush | output | 1 | Branch-cache flush pulse |
| mmu_asid | output | 8 | Address-space tag of the current world |

## Verification
On every cycle, the assertions check the following. The three response kinds never overlap, and rd_data is zero outside a read response. A flush pulse follows only a privileged context write. A User write to the read-only thread register always faults, and a User access never moves mmu_asid. Unaddressed accesses stay silent. Only the bench scenarios can show that each world's copies are separate, that read data is the value last written, and that a faulting or unaddressed write really left the stored values alone when they are read back later.

// File: rtl/ctxid_pkg.sv
package ctxid_pkg;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_CTX  = 3'd1,
    SEL_URW  = 3'd2,
    SEL_URO  = 3'd3,
    SEL_PRV  = 3'd4
  } sel_e;

  localparam int unsigned NUM_WORLDS = 2;
  localparam int unsigned NUM_REGS   = 4;

  // Register choice from the selector fields; SEL_NONE when not addressed
  function automatic sel_e pick_reg(input logic [2:0] op1, input logic [3:0] crn,
                                    input logic [3:0] crm, input logic [2:0] op2,
                                    input logic [3:0] crn_match);
    sel_e s;
    s = SEL_NONE;
    if (op1 == 3'd0 && crn == crn_match && crm == 4'd0) begin
      case (op2)
        3'd1:    s = SEL_CTX;
        3'd2:    s = SEL_URW;
        3'd3:    s = SEL_URO;
        3'd4:    s = SEL_PRV;
        default: s = SEL_NONE;
      endcase
    end
    return s;
  endfunction

  // Permission rule per register kind and mode
  function automatic logic may_access(input sel_e s, input logic is_wr, input logic priv);
    logic ok;
    case (s)
      SEL_URW: ok = 1'b1;
      SEL_URO: ok = priv | ~is_wr;
      SEL_CTX: ok = priv;
      SEL_PRV: ok = priv;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  // Slot number inside one world's bank
  function automatic logic [1:0] slot_of(input sel_e s);
    logic [2:0] t;
    t = 3'(s) - 3'd1;
    return t[1:0];
  endfunction

endpackage

// File: rtl/ctxid_decode.sv
module ctxid_decode
  import ctxid_pkg::*;
#(
  parameter logic [3:0] CRN_MATCH = 4'd13,
  parameter int unsigned IDX_W = 2
) (
  input  logic             valid,
  input  logic             is_wr,
  input  logic [2:0]       op1,
  input  logic [3:0]       crn,
  input  logic [3:0]       crm,
  input  logic [2:0]       op2,
  input  logic             priv,
  output logic             hit,
  output logic             ok_rd,
  output logic             ok_wr,
  output logic             fault,
  output logic             ctx_wr,
  output logic [IDX_W-1:0] slot
);
  sel_e sel;
  logic permit;

  always_comb begin
    sel    = pick_reg(op1, crn, crm, op2, CRN_MATCH);
    hit    = valid && (sel != SEL_NONE);
    permit = may_access(sel, is_wr, priv);
    ok_rd  = hit && permit && !is_wr;
    ok_wr  = hit && permit && is_wr;
    fault  = hit && !permit;
    ctx_wr = ok_wr && (sel == SEL_CTX);
    slot   = IDX_W'(slot_of(sel));
  end
endmodule

// File: rtl/ctxid_bank.sv
module ctxid_bank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREGS  = 4,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_slot,
  output logic [DATA_W-1:0] rd_val,
  output logic [DATA_W-1:0] ctx_val
);
  logic [DATA_W-1:0] regs_q [NREGS];

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_q[r] <= '0;
      else if (wr_en && wr_slot == IDX_W'(r))
        regs_q[r] <= wr_data;
    end
  end

  assign rd_val  = regs_q[rd_slot];
  assign ctx_val = regs_q[0];
endmodule

// File: rtl/ctxid_resp.sv
module ctxid_resp #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ok_rd,
  input  logic              fault,
  input  logic              ctx_wr,
  input  logic [DATA_W-1:0] rd_src,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              undef_exc,
  output logic              bt_flush
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      undef_exc <= 1'b0;
      bt_flush  <= 1'b0;
    end else begin
      rd_data   <= ok_rd ? rd_src : '0;
      rd_valid  <= ok_rd;
      undef_exc <= fault;
      bt_flush  <= ctx_wr;
    end
  end

  // R1
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && undef_exc));
  // R9
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef_exc |-> rd_data == '0);
  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == '0);
endmodule

// File: rtl/ctxid_regfile.sv
module ctxid_regfile
  import ctxid_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ASID_W = 8,
  parameter logic [3:0]  CRN_MATCH = 4'd13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [2:0]        acc_op1,
  input  logic [3:0]        acc_crn,
  input  logic [3:0]        acc_crm,
  input  logic [2:0]        acc_op2,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              acc_ns,
  input  logic              acc_priv,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              undef_exc,
  output logic              bt_flush,
  output logic [ASID_W-1:0] mmu_asid
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS);

  logic             hit, ok_rd, ok_wr, fault, ctx_wr;
  logic [IDX_W-1:0] slot;
  logic [DATA_W-1:0] bank_rd  [NUM_WORLDS];
  logic [DATA_W-1:0] bank_ctx [NUM_WORLDS];

  ctxid_decode #(.CRN_MATCH(CRN_MATCH), .IDX_W(IDX_W)) u_dec (
    .valid(acc_valid), .is_wr(acc_write), .op1(acc_op1), .crn(acc_crn),
    .crm(acc_crm), .op2(acc_op2), .priv(acc_priv), .hit(hit),
    .ok_rd(ok_rd), .ok_wr(ok_wr), .fault(fault), .ctx_wr(ctx_wr), .slot(slot)
  );

  for (genvar w = 0; w < NUM_WORLDS; w++) begin : g_world
    logic bank_we;
    assign bank_we = ok_wr && (acc_ns == w[0]);
    ctxid_bank #(.DATA_W(DATA_W), .NREGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(bank_we), .wr_slot(slot),
      .wr_data(acc_wdata), .rd_slot(slot), .rd_val(bank_rd[w]),
      .ctx_val(bank_ctx[w])
    );
  end

  ctxid_resp #(.DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .ok_rd(ok_rd), .fault(fault), .ctx_wr(ctx_wr),
    .rd_src(bank_rd[acc_ns]), .rd_data(rd_data), .rd_valid(rd_valid),
    .undef_exc(undef_exc), .bt_flush(bt_flush)
  );

  assign mmu_asid = bank_ctx[acc_ns][ASID_W-1:0];

  // R7
  flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bt_flush |-> $past(acc_valid && acc_write && acc_priv && acc_op1 == 3'd0 &&
                       acc_crn == CRN_MATCH && acc_crm == 4'd0 && acc_op2 == 3'd1));
  // R5
  uro_user_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !acc_priv && acc_op1 == 3'd0 && acc_crn == CRN_MATCH &&
     acc_crm == 4'd0 && acc_op2 == 3'd3) |=> undef_exc);
  // R10
  unaddressed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !hit) |=> (!rd_valid && !undef_exc && !bt_flush));
  // R3
  user_asid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_priv) |=> (mmu_asid == $past(mmu_asid) || acc_ns != $past(acc_ns)));
endmodule

// File: tb/tb_ctxid_regfile.sv
module tb_ctxid_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [2:0]  acc_op1 = '0, acc_op2 = '0;
  logic [3:0]  acc_crn = '0, acc_crm = '0;
  logic [31:0] acc_wdata = '0;
  logic        acc_ns = 1'b0, acc_priv = 1'b0;
  logic [31:0] rd_data;
  logic        rd_valid, undef_exc, bt_flush;
  logic [7:0]  mmu_asid;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] model [2][4];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctxid_regfile dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_op1(acc_op1), .acc_crn(acc_crn), .acc_crm(acc_crm), .acc_op2(acc_op2),
    .acc_wdata(acc_wdata), .acc_ns(acc_ns), .acc_priv(acc_priv),
    .rd_data(rd_data), .rd_valid(rd_valid), .undef_exc(undef_exc),
    .bt_flush(bt_flush), .mmu_asid(mmu_asid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic allowed(input logic [2:0] op2, input logic wr, input logic priv);
    if (priv) return 1'b1;
    if (op2 == 3'd2) return 1'b1;
    if (op2 == 3'd3) return !wr;
    return 1'b0;
  endfunction

  // One addressed access, checked against the model; called at a negedge
  task automatic access(input string req, input logic wr, input logic ns, input logic priv,
                        input logic [2:0] op2, input logic [31:0] wd);
    logic ok;
    logic [31:0] e_rd;
    ok = allowed(op2, wr, priv);
    e_rd = (ok && !wr) ? model[ns][op2-1] : 32'h0;
    acc_valid = 1'b1; acc_write = wr; acc_op1 = 3'd0; acc_crn = 4'd13; acc_crm = 4'd0;
    acc_op2 = op2; acc_wdata = wd; acc_ns = ns; acc_priv = priv;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    if (ok && wr) model[ns][op2-1] = wd;
    chk({req, " rd_data"}, rd_data, e_rd);
    chk({req, " rd_valid"}, 32'(rd_valid), 32'(ok && !wr));
    chk({req, " undef_exc"}, 32'(undef_exc), 32'(!ok));
    chk({req, " bt_flush"}, 32'(bt_flush), 32'(ok && wr && op2 == 3'd1));
    chk({req, " mmu_asid"}, 32'(mmu_asid), 32'(model[ns][0][7:0]));
  endtask

  task automatic raw(input string req, input logic wr, input logic [2:0] op1,
                     input logic [3:0] crn, input logic [3:0] crm, input logic [2:0] op2);
    acc_valid = 1'b1; acc_write = wr; acc_op1 = op1; acc_crn = crn; acc_crm = crm;
    acc_op2 = op2; acc_wdata = 32'hDEAD_BEEF; acc_ns = 1'b0; acc_priv = 1'b1;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    chk({req, " silent"}, {29'd0, rd_valid, undef_exc, bt_flush}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R2 reset rd_valid", 32'(rd_valid), 0);
    chk("R2 reset asid", 32'(mmu_asid), 0);
    for (int w = 0; w < 2; w++)
      for (int r = 1; r <= 4; r++) access("R2 reset read", 1'b0, w[0], 1'b1, 3'(r), 0);
  endtask

  task automatic t_ctx();
    access("R3 priv ctx write", 1'b1, 1'b0, 1'b1, 3'd1, 32'h1234_56A5);
    access("R8 ctx read", 1'b0, 1'b0, 1'b1, 3'd1, 0);
    access("R3 user ctx read", 1'b0, 1'b0, 1'b0, 3'd1, 0);
    access("R3 R9 user ctx write", 1'b1, 1'b0, 1'b0, 3'd1, 32'hFFFF_FFFF);
    access("R9 ctx after fault", 1'b0, 1'b0, 1'b1, 3'd1, 0);
  endtask

  task automatic t_urw();
    access("R4 user write", 1'b1, 1'b1, 1'b0, 3'd2, 32'hCAFE_0002);
    access("R4 user read", 1'b0, 1'b1, 1'b0, 3'd2, 0);
    access("R4 priv write", 1'b1, 1'b1, 1'b1, 3'd2, 32'h0BAD_F00D);
    access("R4 priv read", 1'b0, 1'b1, 1'b1, 3'd2, 0);
  endtask

  task automatic t_uro();
    access("R5 priv write", 1'b1, 1'b0, 1'b1, 3'd3, 32'h3333_0003);
    access("R5 user read", 1'b0, 1'b0, 1'b0, 3'd3, 0);
    access("R5 R9 user write", 1'b1, 1'b0, 1'b0, 3'd3, 32'h9999_9999);
    access("R5 R9 readback", 1'b0, 1'b0, 1'b1, 3'd3, 0);
  endtask

  task automatic t_prv();
    access("R6 priv write", 1'b1, 1'b1, 1'b1, 3'd4, 32'h4444_0004);
    access("R6 user read", 1'b0, 1'b1, 1'b0, 3'd4, 0);
    access("R6 R9 user write", 1'b1, 1'b1, 1'b0, 3'd4, 32'h1);
    access("R6 R9 readback", 1'b0, 1'b1, 1'b1, 3'd4, 0);
  endtask

  task automatic t_bank();
    access("R2 ns ctx write", 1'b1, 1'b1, 1'b1, 3'd1, 32'h0000_0177);
    access("R2 s ctx kept", 1'b0, 1'b0, 1'b1, 3'd1, 0);
    access("R2 s urw untouched", 1'b0, 1'b0, 1'b1, 3'd2, 0);
    access("R2 ns uro untouched", 1'b0, 1'b1, 1'b1, 3'd3, 0);
    acc_ns = 1'b0; #1;
    chk("R8 asid secure", 32'(mmu_asid), 32'h0000_00A5);
    acc_ns = 1'b1; #1;
    chk("R8 asid nonsecure", 32'(mmu_asid), 32'h0000_0077);
  endtask

  task automatic t_unaddr();
    raw("R10 op2=0", 1'b1, 3'd0, 4'd13, 4'd0, 3'd0);
    raw("R10 op2=5", 1'b1, 3'd0, 4'd13, 4'd0, 3'd5);
    raw("R10 crn=12", 1'b1, 3'd0, 4'd12, 4'd0, 3'd1);
    raw("R10 crm=1", 1'b1, 3'd0, 4'd13, 4'd1, 3'd2);
    raw("R10 op1=1", 1'b0, 3'd1, 4'd13, 4'd0, 3'd3);
    for (int r = 1; r <= 4; r++) access("R10 readback", 1'b0, 1'b0, 1'b1, 3'(r), 0);
  endtask

  task automatic t_flush_b2b();
    access("R7 flush first", 1'b1, 1'b0, 1'b1, 3'd1, 32'h0000_0011);
    @(negedge clk);
    chk("R7 flush single", 32'(bt_flush), 0);
    access("R7 no flush thread", 1'b1, 1'b0, 1'b1, 3'd2, 32'h5);
    chk("R8 asid follows", 32'(mmu_asid), 32'h11);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin
        for (int w = 0; w < 2; w++) for (int r = 0; r < 4; r++) model[w][r] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctx();
        t_urw();
        t_uro();
        t_prv();
        t_bank();
        t_unaddr();
        t_flush_b2b();
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule